// File: doc/BRIEF.md
# Reference Frequency Qualifier with Hysteresis

This block decides whether one timing reference is usable. Once per measurement window, an external counter delivers the reference's frequency offset against the local oscillator. The offset is a signed number in units of 0.01 ppm and arrives with a one-cycle strobe. The block compares the offset's magnitude against two programmable thresholds. It keeps a registered valid/invalid status that changes only when a strobe arrives.

Each threshold is set by a small code. The code is turned into a level that lies halfway between two adjacent entries of a table whose step is 3.81 ppm. Acceptance uses the accept code. A separate backup-reject code rejects an input that moves quickly off frequency. The space between the two levels forms a hysteresis band. An offset inside that band leaves the status as it is. Rejection can also come from a different source: if the tracking loop loses lock on the reference, the block counts windows and rejects the input once the programmed loss-of-lock timeout runs out.

The status is held in a two-state machine with states `ST_INVALID` and `ST_VALID`. It has four named transitions:
- `ACCEPT` (invalid to valid) when the magnitude is below the accept level and the lock timeout has not expired.
- `FAST_REJECT` (valid to invalid) when the magnitude is above the backup-reject level.
- `LOL_REJECT` (valid to invalid) when the lock timeout expires.
- `HOLD` in every other case.

Top module: `refmon_top`

## Requirements
- R1: While reset is asserted, and after it is released, `ref_ok` is 0 (state `ST_INVALID`). It stays 0 until a strobe causes a change.
- R2: The level for a code c, in 0.01 ppm units, is ((2c+1)·STEP+1)/2 using integer division, with STEP=381. So code 0 gives 191, code 2 gives 953 and code 3 gives 1334.
- R3: In `ST_INVALID`, a strobe whose magnitude is strictly below the accept level moves to `ST_VALID` (transition `ACCEPT`). A magnitude equal to the level does not.
- R4: In `ST_VALID`, a strobe whose magnitude is strictly above the effective reject level moves to `ST_INVALID` (transition `FAST_REJECT`). A magnitude equal to the level does not.
- R5: A strobe whose magnitude lies between the accept level and the effective reject level leaves the state unchanged in both states (`HOLD`).
- R6: The effective reject level is never below the accept level plus GAP, where GAP=46 (0.46 ppm). If the reject code gives a lower level, the accept level plus GAP is used in its place.
- R7: Without a strobe, `ref_ok` does not change, whatever the offset, codes or lock input do.
- R8: On each strobe with `loop_locked`=0, a window counter advances. On a strobe with `loop_locked`=1, it clears. The timeout expires on the strobe that is the N-th consecutive unlocked one, where N=`lol_windows`; a value of 0 acts as 1. Expiry in `ST_VALID` moves to `ST_INVALID` (transition `LOL_REJECT`).
- R9: A negative offset is judged by its magnitude. The most negative code is read as the largest positive magnitude.
- R10: A strobe on which the lock timeout expires never causes `ACCEPT`, even when the magnitude is below the accept level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_stb | input | 1 | One-cycle strobe marking a new window measurement |
| meas_ofs | input | OFS_W | Signed frequency offset, 0.01 ppm per LSB |
| acc_code | input | CODE_W | Accept threshold code |
| rej_code | input | CODE_W | Backup-reject threshold code |
| loop_locked | input | 1 | Tracking loop lock indication, sampled on a strobe |
| lol_windows | input | TMO_W | Loss-of-lock timeout in measurement windows |
| ref_ok | output | 1 | Registered status: 1 = reference valid |

## Verification
The bench uses the default parameters: OFS_W=16, CODE_W=3, TMO_W=4, STEP=381 and GAP=46. A 16-bit offset puts the most negative code, -32768, within direct reach, so the saturating magnitude path can be driven. A 4-bit timeout keeps the loss-of-lock windows short enough to drive the expiry, the lock-return clearing and the zero-value case. With a 3-bit code, codes 0, 2 and 3 land on exact levels of 191, 953 and 1334. The bench probes each of these levels one unit on either side. Swapping the code order also forces the minimum-gap clamp into action.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
    typedef enum logic {
        ST_INVALID = 1'b0,
        ST_VALID   = 1'b1
    } refmon_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/refmon_level.sv
module refmon_level #(
    parameter int CODE_W = 3,
    parameter int STEP   = 381,
    parameter int THR_W  = 13
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [THR_W-1:0]  thr_o
);
    logic [31:0] prod;

    always_comb begin
        // midway between table entry code and code+1 below: (code+0.5)*STEP, rounded
        prod  = ((32'(code_i) * 32'd2) + 32'd1) * 32'(STEP) + 32'd1;
        thr_o = THR_W'(prod >> 1);
    end
endmodule

// File: rtl/refmon_mag.sv
module refmon_mag #(
    parameter int OFS_W = 16,
    localparam int MAG_W = OFS_W - 1
) (
    input  logic signed [OFS_W-1:0] ofs_i,
    output logic [MAG_W-1:0]        mag_o
);
    logic [OFS_W-1:0] neg;

    always_comb begin
        neg = -ofs_i;
        if (!ofs_i[OFS_W-1]) begin
            mag_o = ofs_i[MAG_W-1:0];
        end else if (ofs_i == {1'b1, {MAG_W{1'b0}}}) begin
            mag_o = {MAG_W{1'b1}};
        end else begin
            mag_o = neg[MAG_W-1:0];
        end
    end
endmodule

// File: rtl/refmon_gap.sv
module refmon_gap #(
    parameter int THR_W = 13,
    parameter int GAP   = 46,
    localparam int OUT_W = THR_W + 1
) (
    input  logic [THR_W-1:0] acc_i,
    input  logic [THR_W-1:0] rej_i,
    output logic [OUT_W-1:0] rej_eff_o
);
    logic [OUT_W-1:0] floor_lvl;

    always_comb begin
        floor_lvl = {1'b0, acc_i} + OUT_W'(GAP);
        rej_eff_o = ({1'b0, rej_i} < floor_lvl) ? floor_lvl : {1'b0, rej_i};
    end
endmodule

// File: rtl/refmon_lol.sv
module refmon_lol #(
    parameter int TMO_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             locked_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             expire_o
);
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (stb_i) begin
            if (locked_i) begin
                cnt_q <= '0;
            end else if (cnt_q != {TMO_W{1'b1}}) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        cnt_next = {1'b0, cnt_q} + 1'b1;
        expire_o = !locked_i && ((tmo_i == '0) || (cnt_next >= {1'b0, tmo_i}));
    end

    a_r8_clear_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && locked_i) |=> (cnt_q == '0));

    a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !locked_i && cnt_q != {TMO_W{1'b1}}) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r7_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(cnt_q));
endmodule

// File: rtl/refmon_fsm.sv
module refmon_fsm
    import refmon_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int GAP   = 46
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [CMP_W-1:0] mag_i,
    input  logic [CMP_W-1:0] acc_thr_i,
    input  logic [CMP_W-1:0] rej_thr_i,
    input  logic             expire_i,
    output logic             valid_o
);
    refmon_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (stb_i) begin
            unique case (state_q)
                ST_INVALID: begin
                    if (!expire_i && (mag_i < acc_thr_i)) begin
                        state_d = ST_VALID;        // ACCEPT
                    end
                end
                ST_VALID: begin
                    if (mag_i > rej_thr_i) begin
                        state_d = ST_INVALID;      // FAST_REJECT
                    end else if (expire_i) begin
                        state_d = ST_INVALID;      // LOL_REJECT
                    end
                end
                default: state_d = ST_INVALID;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INVALID;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        valid_o = (state_q == ST_VALID);
    end

    a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(valid_o));

    a_r3_rise_only_below_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(stb_i && (mag_i < acc_thr_i)));

    a_r4_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> $past(stb_i && ((mag_i > rej_thr_i) || expire_i)));

    a_r6_fall_clears_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(valid_o) && !$past(expire_i)) |-> ($past(mag_i) > $past(acc_thr_i) + CMP_W'(GAP)));

    a_r10_no_accept_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && expire_i && !valid_o) |=> !valid_o);
endmodule

// File: rtl/refmon_top.sv
module refmon_top
    import refmon_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int CODE_W = 3,
    parameter int TMO_W  = 4,
    parameter int STEP   = 381,
    parameter int GAP    = 46
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    meas_stb,
    input  logic signed [OFS_W-1:0] meas_ofs,
    input  logic [CODE_W-1:0]       acc_code,
    input  logic [CODE_W-1:0]       rej_code,
    input  logic                    loop_locked,
    input  logic [TMO_W-1:0]        lol_windows,
    output logic                    ref_ok
);
    localparam int MAG_W = OFS_W - 1;
    localparam int THR_W = $clog2(((2 ** (CODE_W + 1)) + 1) * STEP + GAP) + 1;
    localparam int REJ_W = THR_W + 1;
    localparam int CMP_W = int'(max_u(MAG_W, REJ_W)) + 1;

    logic [THR_W-1:0] acc_lvl, rej_lvl;
    logic [REJ_W-1:0] rej_eff;
    logic [MAG_W-1:0] mag;
    logic             lol_expire;

    refmon_level #(.CODE_W(CODE_W), .STEP(STEP), .THR_W(THR_W)) u_acc_lvl (
        .code_i(acc_code),
        .thr_o (acc_lvl)
    );

    refmon_level #(.CODE_W(CODE_W), .STEP(STEP), .THR_W(THR_W)) u_rej_lvl (
        .code_i(rej_code),
        .thr_o (rej_lvl)
    );

    refmon_gap #(.THR_W(THR_W), .GAP(GAP)) u_gap (
        .acc_i    (acc_lvl),
        .rej_i    (rej_lvl),
        .rej_eff_o(rej_eff)
    );

    refmon_mag #(.OFS_W(OFS_W)) u_mag (
        .ofs_i(meas_ofs),
        .mag_o(mag)
    );

    refmon_lol #(.TMO_W(TMO_W)) u_lol (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (meas_stb),
        .locked_i(loop_locked),
        .tmo_i   (lol_windows),
        .expire_o(lol_expire)
    );

    refmon_fsm #(.CMP_W(CMP_W), .GAP(GAP)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_i    (meas_stb),
        .mag_i    (CMP_W'(mag)),
        .acc_thr_i(CMP_W'(acc_lvl)),
        .rej_thr_i(CMP_W'(rej_eff)),
        .expire_i (lol_expire),
        .valid_o  (ref_ok)
    );
endmodule

// File: tb/refmon_top_bench.sv
module refmon_top_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              meas_stb = 1'b0;
    logic signed [15:0] meas_ofs = '0;
    logic [2:0]        acc_code = 3'd2;
    logic [2:0]        rej_code = 3'd3;
    logic              loop_locked = 1'b1;
    logic [3:0]        lol_windows = 4'd3;
    logic              ref_ok;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    refmon_top u_refmon_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_stb   (meas_stb),
        .meas_ofs   (meas_ofs),
        .acc_code   (acc_code),
        .rej_code   (rej_code),
        .loop_locked(loop_locked),
        .lol_windows(lol_windows),
        .ref_ok     (ref_ok)
    );

    task automatic check(input string req, input logic act, input logic exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: ref_ok=%0b expected %0b at %0t", req, act, exp_v, $time);
        end
    endtask

    // one strobe driven at a falling edge, result sampled one falling edge later
    task automatic meas(input int ofs, input logic lk);
        @(negedge clk);
        meas_ofs    = 16'(ofs);
        loop_locked = lk;
        meas_stb    = 1'b1;
        @(negedge clk);
        meas_stb    = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 during reset", ref_ok, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after release", ref_ok, 1'b0);
    endtask

    task automatic t_accept_edge();
        acc_code = 3'd2; rej_code = 3'd3;
        meas(953, 1'b1);  check("R3 equal to 953 stays invalid", ref_ok, 1'b0);
        meas(952, 1'b1);  check("R3 952 accepted", ref_ok, 1'b1);
    endtask

    task automatic t_reject_edge();
        meas(1334, 1'b1); check("R4 equal to 1334 holds valid", ref_ok, 1'b1);
        meas(1000, 1'b1); check("R5 band holds valid", ref_ok, 1'b1);
        meas(1335, 1'b1); check("R4 1335 rejected", ref_ok, 1'b0);
        meas(1000, 1'b1); check("R5 band holds invalid", ref_ok, 1'b0);
    endtask

    task automatic t_code_zero();
        acc_code = 3'd0;
        meas(191, 1'b1);  check("R2 code0 level 191 not accepted", ref_ok, 1'b0);
        meas(190, 1'b1);  check("R2 code0 190 accepted", ref_ok, 1'b1);
        acc_code = 3'd2;
        meas(0, 1'b1);    check("R2 still valid", ref_ok, 1'b1);
    endtask

    task automatic t_negative();
        meas(-1335, 1'b1);  check("R9 -1335 rejected", ref_ok, 1'b0);
        meas(-952, 1'b1);   check("R9 -952 accepted", ref_ok, 1'b1);
        meas(-32768, 1'b1); check("R9 most negative rejected", ref_ok, 1'b0);
        meas(-953, 1'b1);   check("R9 -953 not accepted", ref_ok, 1'b0);
    endtask

    task automatic t_no_strobe();
        meas(0, 1'b1);
        @(negedge clk);
        meas_ofs = 16'sd5000; loop_locked = 1'b0; acc_code = 3'd0; rej_code = 3'd0;
        repeat (6) @(negedge clk);
        check("R7 no strobe keeps valid", ref_ok, 1'b1);
        acc_code = 3'd2; rej_code = 3'd3; loop_locked = 1'b1;
        meas(5000, 1'b1);
        repeat (4) @(negedge clk);
        meas_ofs = 16'sd0;
        repeat (4) @(negedge clk);
        check("R7 no strobe keeps invalid", ref_ok, 1'b0);
    endtask

    task automatic t_gap();
        acc_code = 3'd3; rej_code = 3'd2;   // 1334 and 953 -> effective reject 1380
        meas(0, 1'b1);    check("R6 accept with swapped codes", ref_ok, 1'b1);
        meas(1380, 1'b1); check("R6 1380 held by clamp", ref_ok, 1'b1);
        meas(1381, 1'b1); check("R6 1381 rejected", ref_ok, 1'b0);
        acc_code = 3'd2; rej_code = 3'd3;
    endtask

    task automatic t_lol();
        lol_windows = 4'd3;
        meas(0, 1'b1);
        meas(0, 1'b0); check("R8 unlocked window 1", ref_ok, 1'b1);
        meas(0, 1'b0); check("R8 unlocked window 2", ref_ok, 1'b1);
        meas(0, 1'b0); check("R8 third window rejects", ref_ok, 1'b0);
        meas(0, 1'b1); check("R8 reaccept after lock", ref_ok, 1'b1);
        meas(0, 1'b0); meas(0, 1'b0);
        meas(0, 1'b1); meas(0, 1'b0); meas(0, 1'b0);
        check("R8 lock return cleared count", ref_ok, 1'b1);
        meas(0, 1'b0); check("R8 rejects after fresh count", ref_ok, 1'b0);
        lol_windows = 4'd0;
        meas(0, 1'b1);
        meas(0, 1'b0); check("R8 zero timeout rejects at once", ref_ok, 1'b0);
        lol_windows = 4'd3;
    endtask

    task automatic t_no_accept_expired();
        lol_windows = 4'd1;
        meas(0, 1'b0); check("R10 no accept on expiry", ref_ok, 1'b0);
        meas(0, 1'b1); check("R10 accept once locked", ref_ok, 1'b1);
        lol_windows = 4'd3;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_accept_edge();
        t_reject_edge();
        t_code_zero();
        t_negative();
        t_no_strobe();
        t_gap();
        t_lol();
        t_no_accept_expired();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule